// File: doc/BRIEF.md
# Opcode-Driven Integer ALU with Error Code

This block is a purely combinational arithmetic-logic unit for a 32-bit datapath. It takes two operands and a 4-bit operation selector. It returns a 32-bit result and a 4-bit error code. The operations are:

- add and subtract, in both unsigned and two's complement form;
- signed multiply and signed divide;
- bitwise AND, OR and invert;
- pass-through of either operand;
- constant fill with all zeros or all ones.

In every non-commutative operation the first operand is on the left. The block holds no state and has no clock, so the outputs follow any change on the inputs.

Inside, a decoder turns the operation selector into a packed set of one-hot strobes. A datapath computes every candidate result and error condition, and the strobes select one result and one error. A thin top connects the two. The error code takes one of three values:

- 0000: no error;
- 0001: overflow, in either direction;
- 0010: division by zero.

Top module: `alu_core`

## Requirements
- R1: Opcode 0000 returns the low 32 bits of opA+opB, taking both as unsigned. The error is 0001 exactly when the unsigned sum exceeds 2^32-1, and 0000 otherwise.
- R2: Opcode 0001 returns the low 32 bits of opA-opB, taking both as unsigned. The error is 0001 exactly when opB > opA (a borrow), and 0000 otherwise.
- R3: Opcodes 0010 (add) and 0011 (subtract, opA-opB) work on two's complement values. They return the wrapped low 32 bits. The error is 0001 exactly when the true result lies outside -2^31..2^31-1.
- R4: Opcode 0100 returns the low 32 bits of the signed product opA*opB. The error is 0001 exactly when the full product lies outside -2^31..2^31-1.
- R5: Opcode 0101 with a nonzero divisor returns the signed quotient opA/opB, truncated toward zero, with error 0000. The one exception is the case in R7.
- R6: Opcode 0101 with opB equal to zero returns all zeros with error 0010.
- R7: Opcode 0101 with opA = -2^31 and opB = -1 returns -2^31 with error 0001.
- R8: Opcode 0111 returns opA AND opB, and opcode 1001 returns opA OR opB. Both report error 0000.
- R9: Opcode 1011 returns the bitwise inverse of opA with error 0000. The value of opB has no effect on either output.
- R10: Opcode 1100 returns opA and opcode 1101 returns opB, both with error 0000.
- R11: Opcode 1110 returns all zeros and opcode 1111 returns all ones, both with error 0000.
- R12: The unused opcodes 0110, 1000 and 1010 return all zeros with error 0000.
- R13: The outputs depend only on the present inputs. A change on any input shows up on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | Left operand |
| opB | input | 32 | Right operand |
| opSel | input | 4 | Operation selector |
| result | output | 32 | Operation result |
| errCode | output | 4 | 0000 none, 0001 overflow, 0010 divide by zero |

## Verification
Each opcode is driven with two kinds of operands. Hand-picked operands sit on the edges of the number range: zero, one, all ones, the most negative value and the most positive value. These separate carry from no carry, borrow from no borrow, and the positive overflow of signed add, subtract and multiply from the negative one. They also cover the zero-divisor case and the most-negative divided by minus one case. Random operands, in turn, test ordinary arithmetic and the truncation of signed division. Inverting opA under several different opB values shows that opB has no effect. Changing an input between clock edges, with the opcode unchanged, shows that the outputs follow the inputs with no clock.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W  = 4;
  localparam int ERR_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_UADD  = 4'b0000,
    OP_USUB  = 4'b0001,
    OP_SADD  = 4'b0010,
    OP_SSUB  = 4'b0011,
    OP_SMUL  = 4'b0100,
    OP_SDIV  = 4'b0101,
    OP_AND   = 4'b0111,
    OP_OR    = 4'b1001,
    OP_NOTA  = 4'b1011,
    OP_PASSA = 4'b1100,
    OP_PASSB = 4'b1101,
    OP_ZERO  = 4'b1110,
    OP_ONES  = 4'b1111
  } aluOp_e;

  localparam logic [ERR_W-1:0] ERR_NONE = 4'b0000;
  localparam logic [ERR_W-1:0] ERR_OVF  = 4'b0001;
  localparam logic [ERR_W-1:0] ERR_DIVZ = 4'b0010;

  // One-hot operation strobes from the decoder to the datapath.
  // No strobe set means an all-zero result with no error.
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic isSigned;   // qualifies doAdd / doSub
    logic doMul;
    logic doDiv;
    logic doAnd;
    logic doOr;
    logic doNot;
    logic passA;
    logic passB;
    logic fillOnes;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '0;
    case (opSel)
      OP_UADD:  strobes.doAdd = 1'b1;
      OP_USUB:  strobes.doSub = 1'b1;
      OP_SADD:  begin strobes.doAdd = 1'b1; strobes.isSigned = 1'b1; end
      OP_SSUB:  begin strobes.doSub = 1'b1; strobes.isSigned = 1'b1; end
      OP_SMUL:  strobes.doMul    = 1'b1;
      OP_SDIV:  strobes.doDiv    = 1'b1;
      OP_AND:   strobes.doAnd    = 1'b1;
      OP_OR:    strobes.doOr     = 1'b1;
      OP_NOTA:  strobes.doNot    = 1'b1;
      OP_PASSA: strobes.passA    = 1'b1;
      OP_PASSB: strobes.passB    = 1'b1;
      OP_ONES:  strobes.fillOnes = 1'b1;
      default:  strobes = '0;   // OP_ZERO and the unused codes
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic [ERR_W-1:0]  errCode
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // Adder and subtractor, widened by one bit for carry / borrow.
  logic [DATA_W:0] addWide;
  logic [DATA_W:0] subWide;
  assign addWide = {1'b0, opA} + {1'b0, opB};
  assign subWide = {1'b0, opA} - {1'b0, opB};

  logic signA, signB;
  assign signA = opA[DATA_W-1];
  assign signB = opB[DATA_W-1];

  logic sAddOvf, sSubOvf;
  assign sAddOvf = (signA == signB) && (addWide[DATA_W-1] != signA);
  assign sSubOvf = (signA != signB) && (subWide[DATA_W-1] != signA);

  // Full-width signed product.
  logic signed [PROD_W-1:0] extA, extB, prodWide;
  assign extA     = $signed({{DATA_W{signA}}, opA});
  assign extB     = $signed({{DATA_W{signB}}, opB});
  assign prodWide = extA * extB;

  logic mulOvf;
  assign mulOvf = prodWide[PROD_W-1:DATA_W] != {DATA_W{prodWide[DATA_W-1]}};

  // Divider with a guarded divisor so no undefined division is evaluated.
  logic divByZero, divMinNeg;
  logic [DATA_W-1:0] safeB;
  logic signed [DATA_W-1:0] quot;
  assign divByZero = (opB == '0);
  assign divMinNeg = (opA == MOST_NEG) && (opB == '1);
  assign safeB     = (divByZero || divMinNeg) ? {{(DATA_W-1){1'b0}}, 1'b1} : opB;
  assign quot      = $signed(opA) / $signed(safeB);

  // Result and error select driven by the strobes.
  always_comb begin
    result  = '0;
    errCode = ERR_NONE;
    if (strobes.doAdd) begin
      result = addWide[DATA_W-1:0];
      if (strobes.isSigned ? sAddOvf : addWide[DATA_W]) errCode = ERR_OVF;
    end else if (strobes.doSub) begin
      result = subWide[DATA_W-1:0];
      if (strobes.isSigned ? sSubOvf : subWide[DATA_W]) errCode = ERR_OVF;
    end else if (strobes.doMul) begin
      result = prodWide[DATA_W-1:0];
      if (mulOvf) errCode = ERR_OVF;
    end else if (strobes.doDiv) begin
      if (divByZero) begin
        result  = '0;
        errCode = ERR_DIVZ;
      end else begin
        result = quot;
        if (divMinNeg) errCode = ERR_OVF;
      end
    end else if (strobes.doAnd) begin
      result = opA & opB;
    end else if (strobes.doOr) begin
      result = opA | opB;
    end else if (strobes.doNot) begin
      result = ~opA;
    end else if (strobes.passA) begin
      result = opA;
    end else if (strobes.passB) begin
      result = opB;
    end else if (strobes.fillOnes) begin
      result = '1;
    end
  end

  // Strobe sanity: the decoder never raises two operations at once.
  always_comb begin
    strobe_onehot_chk: assert ($onehot0({strobes.doAdd, strobes.doSub, strobes.doMul,
                                         strobes.doDiv, strobes.doAnd, strobes.doOr,
                                         strobes.doNot, strobes.passA, strobes.passB,
                                         strobes.fillOnes}))
      else $error("more than one operation strobe active");
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] result,
  output logic [ERR_W-1:0]  errCode
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .errCode (errCode)
  );

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    if (opSel == OP_UADD) begin
      // R1
      uadd_carry_chk: assert ((errCode == ERR_OVF) == (result < opA))
        else $error("unsigned add carry flag mismatch");
    end
    if (opSel == OP_USUB) begin
      // R2
      usub_borrow_chk: assert ((errCode == ERR_OVF) == (opB > opA))
        else $error("unsigned subtract borrow flag mismatch");
    end
    if (opSel == OP_SDIV && opB == '0) begin
      // R6
      div_zero_chk: assert (result == '0 && errCode == ERR_DIVZ)
        else $error("divide by zero response wrong");
    end
    if (opSel == OP_SDIV && opA == MOST_NEG && opB == '1) begin
      // R7
      div_min_neg_chk: assert (result == MOST_NEG && errCode == ERR_OVF)
        else $error("most-negative over minus one response wrong");
    end
    if (opSel == OP_AND || opSel == OP_OR) begin
      // R8
      logic_no_err_chk: assert (errCode == ERR_NONE)
        else $error("logic op raised an error");
    end
    if (opSel == OP_NOTA) begin
      // R9
      not_inverse_chk: assert ((result ^ opA) == '1 && errCode == ERR_NONE)
        else $error("invert result wrong");
    end
    if (opSel == OP_ZERO || opSel == OP_ONES) begin
      // R11
      const_fill_chk: assert (result == {DATA_W{opSel[0]}} && errCode == ERR_NONE)
        else $error("constant fill wrong");
    end
    if (opSel == 4'b0110 || opSel == 4'b1000 || opSel == 4'b1010) begin
      // R12
      unused_op_chk: assert (result == '0 && errCode == ERR_NONE)
        else $error("unused opcode produced output");
    end
  end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] opA, opB, result;
  logic [3:0]  opSel, errCode;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  alu_core uut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .errCode(errCode)
  );

  // Behavioural reference built on 64-bit integers.
  task automatic refModel(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic [3:0] e);
    longint unsigned ua, ub, us;
    longint sa, sb, sr;
    ua = a; ub = b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    r = 32'h0; e = 4'd0;
    case (op)
      4'd0: begin us = ua + ub; r = us[31:0]; e = (us > 64'hFFFF_FFFF) ? 4'd1 : 4'd0; end
      4'd1: begin us = ua - ub; r = us[31:0]; e = (ub > ua) ? 4'd1 : 4'd0; end
      4'd2, 4'd3, 4'd4: begin
        sr = (op == 4'd2) ? sa + sb : (op == 4'd3) ? sa - sb : sa * sb;
        r = sr[31:0];
        e = (sr > 64'sd2147483647 || sr < -64'sd2147483648) ? 4'd1 : 4'd0;
      end
      4'd5: begin
        if (b == 0) begin r = 0; e = 4'd2; end
        else begin sr = sa / sb; r = sr[31:0];
          e = (sr > 64'sd2147483647) ? 4'd1 : 4'd0; end
      end
      4'd7:  r = a & b;
      4'd9:  r = a | b;
      4'd11: r = ~a;
      4'd12: r = a;
      4'd13: r = b;
      4'd15: r = 32'hFFFF_FFFF;
      default: r = 0;
    endcase
  endtask

  function automatic string reqOf(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return (b == 0) ? "R6" : (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ? "R7" : "R5";
      4'd7, 4'd9: return "R8";
      4'd11: return "R9";
      4'd12, 4'd13: return "R10";
      4'd14, 4'd15: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic compareNow(input string tag);
    logic [31:0] er; logic [3:0] ee;
    refModel(opSel, opA, opB, er, ee);
    checkCount++;
    if (result !== er || errCode !== ee) begin
      failCount++;
      $display("FAIL %s op=%b a=%h b=%h: result=%h err=%b expected result=%h err=%b",
               tag, opSel, opA, opB, result, errCode, er, ee);
    end
  endtask

  // Drive on the rising edge, compare on the falling edge.
  task automatic applyCheck(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    opSel = op; opA = a; opB = b;
    @(negedge clk);
    compareNow(reqOf(op, a, b));
  endtask

  localparam logic [31:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [31:0] MINN = 32'h8000_0000;

  initial begin
    opA = 0; opB = 0; opSel = 0;
    repeat (3) @(posedge clk);
    // Quiescent output with all-zero inputs (R1: 0+0 = 0, no error).
    @(negedge clk);
    compareNow("R1");
    rstN = 1'b1;

    // Directed edge operands across every opcode.
    for (int op = 0; op < 16; op++) begin
      applyCheck(4'(op), 32'h0, 32'h0);
      applyCheck(4'(op), 32'hFFFF_FFFF, 32'h1);          // R1 carry, R2 no borrow
      applyCheck(4'(op), 32'h1, 32'h2);                  // R2 borrow
      applyCheck(4'(op), MAXP, 32'h1);                   // R3 positive overflow on add
      applyCheck(4'(op), MINN, 32'h1);                   // R3 negative overflow on sub
      applyCheck(4'(op), MINN, 32'hFFFF_FFFF);           // R7 / R4 overflow
      applyCheck(4'(op), 32'h0001_0000, 32'h0001_0000);  // R4 positive overflow
      applyCheck(4'(op), 32'h0001_0000, 32'hFFFF_0000);  // R4 negative overflow
      applyCheck(4'(op), 32'hFFFF_FFF9, 32'h2);          // R5 -7/2 = -3
      applyCheck(4'(op), 32'h7, 32'hFFFF_FFFE);          // R5 7/-2 = -3
      applyCheck(4'(op), 32'h1234_5678, 32'h0);          // R6 zero divisor
      applyCheck(4'(op), 32'hF0F0_A5A5, 32'h0FF0_5A5A);  // R8 patterns
    end

    // R9: invert ignores opB, several opB values against the same opA.
    for (int k = 0; k < 4; k++)
      applyCheck(4'b1011, 32'hA5A5_0F0F, 32'h1111_1111 * 32'(k));

    // R12: unused opcodes with busy operands.
    applyCheck(4'b0110, 32'hDEAD_BEEF, 32'h1234_5678);
    applyCheck(4'b1000, 32'hDEAD_BEEF, 32'h1234_5678);
    applyCheck(4'b1010, 32'hDEAD_BEEF, 32'h1234_5678);

    // Random operands on every opcode (R1..R12).
    for (int n = 0; n < 1500; n++)
      applyCheck(4'($urandom_range(15)), $urandom, ($urandom_range(7) == 0) ? 32'h0 : $urandom);

    // R13: change inputs between clock edges with the opcode held.
    @(negedge clk);
    opSel = 4'b0000; opA = 32'd5; opB = 32'd6;
    #1 compareNow("R13");
    opA = 32'd100;
    #1 compareNow("R13");
    opB = 32'hFFFF_FFF0;
    #1 compareNow("R13");
    opSel = 4'b1101;
    #1 compareNow("R13");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule